// File: doc/BRIEF.md
# Peripheral Address Decoder with Wait States

This block takes a strobed 24-bit CPU address and picks one destination for it: one of five internal peripheral slots, an internal RAM window, or the external memory interface. Each internal target is gated twice. A global peripheral-enable bit must be set, and the target's own bit in an 8-bit enable register must also be set. An access whose address matches a target that is gated off goes to the external interface as if the internal target did not exist.

Peripheral-slot accesses are word-only. A slot access holds that slot's select line and inserts two wait states before it raises ready for one cycle. A byte request to a slot is never forwarded. It returns ready with a one-cycle error flag and raises no select. RAM accesses complete with no wait state. The RAM word offset comes from the low 14 address bits, so the window repeats every 16 KB across banks 09h to 0Fh. External accesses produce a one-cycle external select and leave the acknowledge to the external interface.

Top module: `pdec_top`

## Requirements
- R1: After reset all selects, ready and error are low, and both the global enable and the slot-enable register read as cleared. An access to 00_EF00h therefore goes to the external select.
- R2: With the global enable set, an address in bank 00h with address bits [15:8] equal to EFh, EEh, EDh, ECh or E9h selects slot_sel_o bit 0, 1, 2, 3 or 4 respectively. This happens only when enable-register bit 0, 1, 4, 6 or 7 (in the same order) is set.
- R3: An address in a slot window whose own enable bit is clear raises the external select instead.
- R4: While the global enable is clear, every address, including the slot and RAM ranges, raises the external select.
- R5: With the global enable and enable bit 3 set, any address in banks 09h to 0Fh (bits [23:16]) raises ram_sel_o and ready_o together for one cycle, in the cycle after the strobe. ram_off_o equals address bits [13:0]. Byte and word requests behave the same.
- R6: A word access to a slot raises that slot's select in the cycle after the strobe and holds it for three cycles. ready_o is high only in the last of these cycles, which is the third cycle after the strobe.
- R7: A byte request (byte_i = 1) to an enabled slot raises no select. error_o and ready_o are both high for exactly one cycle, the third cycle after the strobe.
- R8: Strobes that arrive while a slot or error access is in progress, including its ready cycle, are ignored. After the ready cycle all outputs are low.
- R9: At most one select is active at a time. An address that matches no enabled internal target raises ext_sel_o for one cycle after the strobe, with ready_o low. Byte and word requests behave the same.
- R10: A cycle with cfg_wr_i high loads the global enable and the enable register from cfg_glb_i and cfg_en_i. Strobes in later cycles are decoded with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Load enable configuration |
| cfg_glb_i | input | 1 | Global peripheral enable value |
| cfg_en_i | input | 8 | Per-target enable bits |
| req_i | input | 1 | Access strobe |
| addr_i | input | 24 | CPU address |
| byte_i | input | 1 | 1 = byte request, 0 = word |
| slot_sel_o | output | 5 | One select per peripheral slot |
| ram_sel_o | output | 1 | Internal RAM select |
| ram_off_o | output | 14 | Offset within the RAM window |
| ext_sel_o | output | 1 | External interface select |
| ready_o | output | 1 | Access acknowledge for internal targets |
| error_o | output | 1 | Illegal byte access to a slot |

## Verification
The bench sweeps both global-enable values and all 256 enable-register patterns. For each configuration it sends addresses across pages E8h to F0h of bank 00h and across banks 08h, 09h, 0Ch, 0Fh and 10h. Because of this sweep, a decoder that ignores one enable bit, swaps two bit positions, or misses a bank edge of the RAM mirror sends some access to the wrong select. Slot accesses are checked in every cycle. A counter that is off by one raises ready a cycle early or late.

During every slot access the bench keeps strobing an unrelated address. A design that accepts strobes while busy raises a second select. Byte requests are mixed in throughout, so a design that forwards them to a slot, or that omits the error flag, shows up as a wrong select or a missing error pulse.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
    localparam int N_SLOT = 5;
    // address bits [15:8] of each slot window, slot 0 first
    localparam logic [7:0] SLOT_PAGE [N_SLOT] = '{8'hEF, 8'hEE, 8'hED, 8'hEC, 8'hE9};
    // enable-register bit owning each slot
    localparam int SLOT_BIT [N_SLOT] = '{0, 1, 4, 6, 7};

    typedef enum logic [1:0] {
        TGT_EXT  = 2'd0,
        TGT_SLOT = 2'd1,
        TGT_RAM  = 2'd2,
        TGT_BAD  = 2'd3
    } tgt_e;
endpackage

// File: rtl/pdec_cfg.sv
module pdec_cfg #(
    parameter int EN_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_i,
    input  logic            glb_i,
    input  logic [EN_W-1:0] en_i,
    output logic            glb_o,
    output logic [EN_W-1:0] en_o
);
    typedef struct packed {
        logic            glb;
        logic [EN_W-1:0] en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            cfg_d.glb = glb_i;
            cfg_d.en  = en_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign glb_o = cfg_q.glb;
    assign en_o  = cfg_q.en;

    // R10
    cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (glb_o == $past(glb_i)) && (en_o == $past(en_i)));
endmodule

// File: rtl/pdec_match.sv
module pdec_match
    import pdec_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int EN_W        = 8,
    parameter int RAM_EN_BIT  = 3,
    parameter int RAM_BANK_LO = 9,
    parameter int RAM_BANK_HI = 15
) (
    input  logic [ADDR_W-1:8] addr_i,
    input  logic              byte_i,
    input  logic              glb_i,
    input  logic [EN_W-1:0]   en_i,
    output tgt_e              tgt_o,
    output logic [N_SLOT-1:0] slot_hit_o
);
    localparam int BANK_W = ADDR_W - 16;

    logic [BANK_W-1:0] bank;
    logic [7:0]        page;
    logic              bank_zero;
    logic              ram_hit;
    logic              unused_en;

    assign bank      = addr_i[ADDR_W-1:16];
    assign page      = addr_i[15:8];
    assign bank_zero = (bank == '0);
    assign unused_en = ^en_i;

    for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
        assign slot_hit_o[k] = glb_i && en_i[SLOT_BIT[k]] && bank_zero
                               && (page == SLOT_PAGE[k]);
    end

    assign ram_hit = glb_i && en_i[RAM_EN_BIT]
                     && (bank >= BANK_W'(RAM_BANK_LO))
                     && (bank <= BANK_W'(RAM_BANK_HI));

    always_comb begin
        if (|slot_hit_o)  tgt_o = byte_i ? TGT_BAD : TGT_SLOT;
        else if (ram_hit) tgt_o = TGT_RAM;
        else              tgt_o = TGT_EXT;
    end

    // R9
    slot_unique_chk: assert final ($onehot0(slot_hit_o));
endmodule

// File: rtl/pdec_seq.sv
module pdec_seq
    import pdec_pkg::*;
#(
    parameter int RAM_AW = 14,
    parameter int WAIT_N = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  tgt_e              tgt_i,
    input  logic [N_SLOT-1:0] slot_hit_i,
    input  logic [RAM_AW-1:0] off_i,
    output logic [N_SLOT-1:0] slot_sel_o,
    output logic              ram_sel_o,
    output logic [RAM_AW-1:0] ram_off_o,
    output logic              ext_sel_o,
    output logic              ready_o,
    output logic              error_o
);
    localparam int CW = $clog2(WAIT_N + 1);

    typedef struct packed {
        logic              busy;
        logic              bad;
        logic [CW-1:0]     cnt;
        logic [N_SLOT-1:0] slot;
        logic              ram;
        logic              ext;
        logic              rdy;
        logic              err;
        logic [RAM_AW-1:0] off;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b0;
        st_d.err = 1'b0;
        if (st_q.busy) begin
            if (st_q.rdy) begin
                st_d.busy = 1'b0;
                st_d.bad  = 1'b0;
                st_d.slot = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CW'(WAIT_N - 1)) begin
                    st_d.rdy = 1'b1;
                    st_d.err = st_q.bad;
                end
            end
        end else begin
            st_d.slot = '0;
            st_d.ram  = 1'b0;
            st_d.ext  = 1'b0;
            st_d.bad  = 1'b0;
            st_d.off  = '0;
            if (req_i) begin
                st_d.cnt = '0;
                unique case (tgt_i)
                    TGT_SLOT: begin
                        st_d.busy = 1'b1;
                        st_d.slot = slot_hit_i;
                    end
                    TGT_BAD: begin
                        st_d.busy = 1'b1;
                        st_d.bad  = 1'b1;
                    end
                    TGT_RAM: begin
                        st_d.ram = 1'b1;
                        st_d.rdy = 1'b1;
                        st_d.off = off_i;
                    end
                    default: st_d.ext = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign slot_sel_o = st_q.slot;
    assign ram_sel_o  = st_q.ram;
    assign ram_off_o  = st_q.off;
    assign ext_sel_o  = st_q.ext;
    assign ready_o    = st_q.rdy;
    assign error_o    = st_q.err;

    // R9
    one_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({slot_sel_o, ram_sel_o, ext_sel_o}));
    // R9
    ext_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_sel_o |-> !ready_o);
    // R5
    ram_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ram_sel_o |-> ready_o);
    // R6
    slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|slot_sel_o && !ready_o) |=> $stable(slot_sel_o));
    // R6
    slot_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|slot_sel_o && ready_o) |-> ($past(|slot_sel_o, 1) && $past(|slot_sel_o, 2)
                                      && !$past(ready_o, 1)));
    // R7
    err_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_o |-> (ready_o && slot_sel_o == '0 && !ram_sel_o && !ext_sel_o));
    // R7
    err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_o |=> !error_o);
    // R8
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CW'(WAIT_N));
endmodule

// File: rtl/pdec_top.sv
module pdec_top
    import pdec_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int EN_W        = 8,
    parameter int RAM_AW      = 14,
    parameter int RAM_EN_BIT  = 3,
    parameter int RAM_BANK_LO = 9,
    parameter int RAM_BANK_HI = 15,
    parameter int WAIT_N      = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_wr_i,
    input  logic              cfg_glb_i,
    input  logic [EN_W-1:0]   cfg_en_i,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_i,
    output logic [N_SLOT-1:0] slot_sel_o,
    output logic              ram_sel_o,
    output logic [RAM_AW-1:0] ram_off_o,
    output logic              ext_sel_o,
    output logic              ready_o,
    output logic              error_o
);
    logic              glb;
    logic [EN_W-1:0]   en;
    tgt_e              tgt;
    logic [N_SLOT-1:0] slot_hit;

    pdec_cfg #(.EN_W(EN_W)) cfg_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .wr_i  (cfg_wr_i),
        .glb_i (cfg_glb_i),
        .en_i  (cfg_en_i),
        .glb_o (glb),
        .en_o  (en)
    );

    pdec_match #(
        .ADDR_W     (ADDR_W),
        .EN_W       (EN_W),
        .RAM_EN_BIT (RAM_EN_BIT),
        .RAM_BANK_LO(RAM_BANK_LO),
        .RAM_BANK_HI(RAM_BANK_HI)
    ) match_i (
        .addr_i    (addr_i[ADDR_W-1:8]),
        .byte_i    (byte_i),
        .glb_i     (glb),
        .en_i      (en),
        .tgt_o     (tgt),
        .slot_hit_o(slot_hit)
    );

    pdec_seq #(
        .RAM_AW(RAM_AW),
        .WAIT_N(WAIT_N)
    ) seq_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (req_i),
        .tgt_i     (tgt),
        .slot_hit_i(slot_hit),
        .off_i     (addr_i[RAM_AW-1:0]),
        .slot_sel_o(slot_sel_o),
        .ram_sel_o (ram_sel_o),
        .ram_off_o (ram_off_o),
        .ext_sel_o (ext_sel_o),
        .ready_o   (ready_o),
        .error_o   (error_o)
    );

    // R4
    glb_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !glb && !ready_o && slot_sel_o == '0 && !error_o
         && !ram_sel_o && !ext_sel_o) |=> (ext_sel_o || |slot_sel_o || error_o || ready_o
                                           || $past(cfg_wr_i)));
endmodule

// File: tb/pdec_top_tb_top.sv
`timescale 1ns/100ps
module pdec_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_glb = 1'b0;
    logic [7:0]  cfg_en = '0;
    logic        req = 1'b0;
    logic [23:0] addr = '0;
    logic        byt = 1'b0;
    logic [4:0]  slot_sel;
    logic        ram_sel;
    logic [13:0] ram_off;
    logic        ext_sel;
    logic        ready;
    logic        error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pdec_top dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .cfg_wr_i  (cfg_wr),
        .cfg_glb_i (cfg_glb),
        .cfg_en_i  (cfg_en),
        .req_i     (req),
        .addr_i    (addr),
        .byte_i    (byt),
        .slot_sel_o(slot_sel),
        .ram_sel_o (ram_sel),
        .ram_off_o (ram_off),
        .ext_sel_o (ext_sel),
        .ready_o   (ready),
        .error_o   (error)
    );

    // output bundle {slot[4:0], ram, ext, ready, error}
    function automatic logic [8:0] outs();
        return {slot_sel, ram_sel, ext_sel, ready, error};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h addr=%h glb=%0d en=%h byte=%0d",
                     tag, act, exp, addr, cfg_glb, cfg_en, byt);
        end
    endtask

    task automatic write_cfg(input logic g, input logic [7:0] e);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_glb = g; cfg_en = e;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // reference decode: kind 0 ext, 1 slot, 2 ram, 3 bad byte
    function automatic int page_slot(input logic [7:0] pg);
        case (pg)
            8'hEF: return 0;
            8'hEE: return 1;
            8'hED: return 2;
            8'hEC: return 3;
            8'hE9: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic int slot_bit(input int s);
        case (s)
            0: return 0;
            1: return 1;
            2: return 4;
            3: return 6;
            default: return 7;
        endcase
    endfunction

    task automatic access(input logic [23:0] a, input logic b, input logic g,
                          input logic [7:0] e);
        int s;
        int kind;
        string tag;
        logic [8:0] exp1;
        s = (a[23:16] == 8'h00) ? page_slot(a[15:8]) : -1;
        kind = 0;
        tag = g ? "R9" : "R4";
        if (s >= 0 && !g) tag = "R4";
        else if (s >= 0 && !e[slot_bit(s)]) tag = "R3";
        if (g && s >= 0 && e[slot_bit(s)]) begin
            kind = b ? 3 : 1;
            tag = b ? "R7" : "R2 R6";
        end else if (g && e[3] && a[23:16] >= 8'h09 && a[23:16] <= 8'h0F) begin
            kind = 2;
            tag = "R5";
        end
        @(negedge clk);
        req = 1'b1; addr = a; byt = b;
        @(negedge clk);
        if (kind == 1)      exp1 = {5'(1 << s), 4'b0000};
        else if (kind == 3) exp1 = 9'b0;
        else if (kind == 2) exp1 = {5'b0, 4'b1010};
        else                exp1 = {5'b0, 4'b0100};
        chk(32'(outs()), 32'(exp1), {tag, " R10 cycle1"});
        if (kind == 2) chk(32'(ram_off), 32'(a[13:0]), "R5 offset");
        if (kind == 1 || kind == 3) begin
            // unrelated strobes during the access must be ignored
            addr = 24'h00_0000; byt = 1'b0;
            @(negedge clk);
            chk(32'(outs()), 32'(exp1), {tag, " R8 cycle2"});
            @(negedge clk);
            if (kind == 1) chk(32'(outs()), 32'({5'(1 << s), 4'b0010}), {tag, " cycle3"});
            else           chk(32'(outs()), 32'({5'b0, 4'b0011}), {tag, " cycle3"});
            @(negedge clk);
            req = 1'b0;
            chk(32'(outs()), 32'(0), "R8 after ready");
        end else begin
            req = 1'b0;
            @(negedge clk);
            chk(32'(outs()), 32'(0), {tag, " one cycle"});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(32'(outs()), 32'(0), "R1 reset outputs");
        rst_n = 1'b1;
        // R1: cleared configuration sends a slot address outside
        access(24'h00_EF00, 1'b0, 1'b0, 8'h00);
        for (int c = 0; c < 512; c++) begin
            logic g;
            logic [7:0] e;
            g = c[8];
            e = c[7:0];
            write_cfg(g, e);
            for (int i = 0; i < 14; i++) begin
                logic [23:0] a;
                logic b;
                if (i < 9) begin
                    a = {8'h00, 8'(8'hE8 + i), 8'((i * 37 + c) & 8'hFF)};
                end else begin
                    logic [7:0] bk;
                    case (i)
                        9:  bk = 8'h08;
                        10: bk = 8'h09;
                        11: bk = 8'h0C;
                        12: bk = 8'h0F;
                        default: bk = 8'h10;
                    endcase
                    a = {bk, 16'((c * 1237 + i * 97) & 16'hFFFF)};
                end
                b = 1'((c ^ i) & 1);
                access(a, b, g, e);
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule